// File: doc/BRIEF.md
# Panel SPI Initialization Sequencer

This block brings a small TFT panel controller up from power-on and then moves it between active and standby. When the power-good input rises it asserts the panel reset output for a programmable time, releases it, waits a short settle time, and then writes a fixed initialization table from an internal ROM to the panel. Each register write is one 16-bit frame on a write-only, 3-wire SPI master that runs in mode 3. After the table has been written the block waits for requests from the host. An enable request wakes the panel and turns on the backlight after a long delay. A disable request turns the backlight off and puts the panel in standby. A shutdown request does the same and then puts the panel back into reset. The host can also write a single register directly. The block refuses writes to addresses that the panel reserves.

Every delay is a parameter given in clock cycles: the SPI half-period, the reset hold time, the settle gap after a write, and the backlight delay. Requests that arrive while the block is busy are kept in one-deep pending slots and are served once it is free, so none is lost.

Top module: `panel_init_seq`

## Requirements
- R1: While the block's own reset is active and just after it is released, `panel_rst` is 1, `spi_sclk` is 1, `spi_cs_n` is 1, `bl_en` is 0 and `busy` is 0.
- R2: Each write is one frame, with `spi_cs_n` low for exactly 16 rising edges of `spi_sclk`. The frame is sent MSB first. Bits 15:10 hold the register address, bit 9 is the write flag and is 1, bit 8 is 0, and bits 7:0 hold the value.
- R3: SPI mode 3. `spi_sclk` is high whenever `spi_cs_n` is high. `spi_sdo` changes only on a falling edge of `spi_sclk` and is stable at each rising edge. `spi_cs_n` stays high for at least 2*SCLK_HALF cycles between frames.
- R4: When `pwr_good` rises, `panel_rst` stays high for RST_CYC to RST_CYC+3 cycles and then falls. The first frame starts at least GAP_CYC cycles after `panel_rst` falls.
- R5: The initialization table is written in ascending address order, to addresses 0x00 through 0x12 and then 0x20. The values are: 00 00 03 CC 46 05 00 00 08 40 88 88 20 20 67 A4 04 24 24, and 00 for address 0x20.
- R6: `spi_cs_n` stays high for at least GAP_CYC cycles between any two frames.
- R7: `busy` is high from the rise of `pwr_good` until the last table frame and its gap have finished. An enable or disable request made while busy is held and served later. If both are pending, the later one wins, and the other is never sent.
- R8: An enable request sends value 0x03 to address 0 (frame 0x0203). `bl_en` rises between BL_CYC and BL_CYC+2*SCLK_HALF+4 cycles after `spi_cs_n` rises at the end of that frame.
- R9: A disable request drops `bl_en` before its frame starts, then sends value 0x01 to address 0 (frame 0x0201).
- R10: A shutdown request drops `bl_en`, sends frame 0x0201, and then sets `panel_rst` high. `busy` is then 0 until the next rising edge of `pwr_good`. `bl_en` is never 1 while `panel_rst` is 1.
- R11: A host write (`wr_req` with `wr_addr`, `wr_data`) sends one frame. Addresses 0x13 to 0x1D, 0x1F and anything above 0x20 are protected. A write to a protected address sends no frame, and `wr_err` is 1 in the cycle after the request. A write to a legal address leaves `wr_err` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| pwr_good | input | 1 | Panel supply good; a rising edge starts bring-up |
| en_req | input | 1 | One-cycle pulse: make the panel active and turn on the backlight |
| dis_req | input | 1 | One-cycle pulse: put the panel in standby |
| shut_req | input | 1 | One-cycle pulse: standby, then panel reset |
| wr_req | input | 1 | One-cycle pulse: host register write |
| wr_addr | input | 6 | Register address for the host write |
| wr_data | input | 8 | Register value for the host write |
| panel_rst | output | 1 | Panel reset, active high |
| spi_sclk | output | 1 | SPI clock, idles high |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_sdo | output | 1 | SPI serial data |
| bl_en | output | 1 | Backlight enable |
| busy | output | 1 | Reset, table writing or a command is in progress |
| wr_err | output | 1 | One-cycle pulse: a host write to a protected address was dropped |

## Verification
Each result has a known delay. `wr_err` follows a host request after one cycle. The reset hold ends RST_CYC+1 cycles after `pwr_good` rises. `bl_en` rises BL_CYC+2*SCLK_HALF+1 cycles after the enable frame's `spi_cs_n` rises. A frame's first bit is valid SCLK_HALF cycles after `spi_cs_n` falls. The bench samples every output on the falling clock edge. It decodes frames from the rising edges of `spi_sclk` and compares each one, as it ends, against the next entry in a queue of expected frames. Delays that can move by a cycle or two are checked against a window derived from the parameters rather than a single cycle.

// File: rtl/pis_pkg.sv
package pis_pkg;
   localparam int FRAME_W  = 16;
   localparam int ADDR_W   = 6;
   localparam int DATA_W   = 8;
   localparam int BIT_W    = $clog2(FRAME_W);
   localparam int INIT_LEN = 20;
   localparam int IDX_W    = $clog2(INIT_LEN);

   typedef enum logic [3:0] {
      ST_OFF, ST_RST, ST_POST, ST_INIT_TX, ST_INIT_WAIT, ST_INIT_GAP,
      ST_READY, ST_CMD_WAIT, ST_CMD_GAP
   } seq_st_e;

   typedef enum logic [1:0] {CMD_EN, CMD_DIS, CMD_SHUT, CMD_WR} cmd_e;

   // Reserved window, the single reserved slot, and everything past the top register
   function automatic logic is_protected(input logic [ADDR_W-1:0] a);
      return ((a >= 6'h13) && (a <= 6'h1D)) || (a == 6'h1F) || (a > 6'h20);
   endfunction

   // Address in the upper six bits, then write flag, a zero pad bit, then the value
   function automatic logic [FRAME_W-1:0] mk_frame(input logic [ADDR_W-1:0] a,
                                                  input logic [DATA_W-1:0] d);
      return {a, 1'b1, 1'b0, d};
   endfunction
endpackage

// File: rtl/pis_rom.sv
module pis_rom
   import pis_pkg::*;
(
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data
);
   // Entries 0..18 map onto addresses 0x00..0x12; the last entry targets 0x20
   always_comb begin
      addr = (idx == IDX_W'(INIT_LEN-1)) ? 6'h20 : ADDR_W'(idx);
      case (idx)
         5'd2:    data = 8'h03;
         5'd3:    data = 8'hCC;
         5'd4:    data = 8'h46;
         5'd5:    data = 8'h05;
         5'd8:    data = 8'h08;
         5'd9:    data = 8'h40;
         5'd10,
         5'd11:   data = 8'h88;
         5'd12,
         5'd13:   data = 8'h20;
         5'd14:   data = 8'h67;
         5'd15:   data = 8'hA4;
         5'd16:   data = 8'h04;
         5'd17,
         5'd18:   data = 8'h24;
         default: data = 8'h00;
      endcase
   end
endmodule

// File: rtl/pis_spi_tx.sv
module pis_spi_tx
   import pis_pkg::*;
#(
   parameter int SCLK_HALF = 4,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] frame,
   output logic               ready,
   output logic               done,
   output logic               sclk,
   output logic               cs_n,
   output logic               sdo
);
   localparam int CW = $clog2(2*SCLK_HALF) + 1;
   localparam logic [CW-1:0]    HALF_M1  = CW'(SCLK_HALF - 1);
   localparam logic [CW-1:0]    GUARD_M1 = CW'(2*SCLK_HALF - 1);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

   if (SCLK_HALF < 1) begin : g_bad_half
      initial $fatal(1, "pis_spi_tx: SCLK_HALF must be at least 1");
   end

   typedef enum logic [2:0] {TX_IDLE, TX_SETUP, TX_LO, TX_HI, TX_GUARD} tx_st_e;

   tx_st_e             st;
   logic [CW-1:0]      cnt;
   logic [BIT_W-1:0]   bitn;
   logic [FRAME_W-1:0] shreg, shreg_nx;
   logic               first_bit, next_bit;

   if (MSB_FIRST) begin : g_msb
      assign first_bit = frame[FRAME_W-1];
      assign shreg_nx  = {shreg[FRAME_W-2:0], 1'b0};
      assign next_bit  = shreg[FRAME_W-2];
   end else begin : g_lsb
      assign first_bit = frame[0];
      assign shreg_nx  = {1'b0, shreg[FRAME_W-1:1]};
      assign next_bit  = shreg[1];
   end

   assign ready = (st == TX_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= TX_IDLE;
         cnt   <= '0;
         bitn  <= '0;
         shreg <= '0;
         sclk  <= 1'b1;
         cs_n  <= 1'b1;
         sdo   <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            TX_IDLE: if (start) begin
               shreg <= frame;
               sdo   <= first_bit;
               cs_n  <= 1'b0;
               bitn  <= '0;
               cnt   <= HALF_M1;
               st    <= TX_SETUP;
            end
            TX_SETUP: if (cnt == '0) begin
               sclk <= 1'b0;
               cnt  <= HALF_M1;
               st   <= TX_LO;
            end else cnt <= cnt - 1'b1;
            TX_LO: if (cnt == '0) begin
               sclk <= 1'b1;
               cnt  <= HALF_M1;
               st   <= TX_HI;
            end else cnt <= cnt - 1'b1;
            TX_HI: if (cnt == '0) begin
               if (bitn == LAST_BIT) begin
                  cs_n <= 1'b1;
                  cnt  <= GUARD_M1;
                  st   <= TX_GUARD;
               end else begin
                  bitn  <= bitn + 1'b1;
                  shreg <= shreg_nx;
                  sdo   <= next_bit;
                  sclk  <= 1'b0;
                  cnt   <= HALF_M1;
                  st    <= TX_LO;
               end
            end else cnt <= cnt - 1'b1;
            TX_GUARD: if (cnt == '0) begin
               done <= 1'b1;
               st   <= TX_IDLE;
            end else cnt <= cnt - 1'b1;
            default: st <= TX_IDLE;
         endcase
      end
   end

   p_idle_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk);
   p_sdo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> $stable(sdo));
   p_start_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ready) |=> !cs_n);
endmodule

// File: rtl/pis_ctrl.sv
module pis_ctrl
   import pis_pkg::*;
#(
   parameter int RST_CYC = 20000,
   parameter int GAP_CYC = 400,
   parameter int BL_CYC  = 30000000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pwr_good,
   input  logic               en_req,
   input  logic               dis_req,
   input  logic               shut_req,
   input  logic               wr_req,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               spi_ready,
   input  logic               spi_done,
   output logic               spi_start,
   output logic [FRAME_W-1:0] spi_frame,
   output logic               panel_rst,
   output logic               bl_en,
   output logic               busy,
   output logic               wr_err
);
   localparam int TMAX = (RST_CYC > GAP_CYC) ? RST_CYC : GAP_CYC;
   localparam int TW   = $clog2(TMAX + 1);
   localparam int BW   = $clog2(BL_CYC + 1);
   localparam logic [TW-1:0]    RST_M1 = TW'(RST_CYC - 1);
   localparam logic [TW-1:0]    GAP_M1 = TW'(GAP_CYC - 1);
   localparam logic [BW-1:0]    BL_M1  = BW'(BL_CYC - 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(INIT_LEN - 1);
   localparam logic [DATA_W-1:0] V_ACTIVE  = 8'h03;
   localparam logic [DATA_W-1:0] V_STANDBY = 8'h01;

   if (RST_CYC < 1 || GAP_CYC < 1 || BL_CYC < 1) begin : g_bad_time
      initial $fatal(1, "pis_ctrl: delay parameters must be at least 1");
   end

   seq_st_e           st;
   cmd_e              cmd;
   logic [TW-1:0]     tmr;
   logic [BW-1:0]     bl_cnt;
   logic              bl_arm;
   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] rom_addr;
   logic [DATA_W-1:0] rom_data;
   logic              pg_q;
   logic              pend_en, pend_dis, pend_shut, pend_wr;
   logic [ADDR_W-1:0] pw_addr;
   logic [DATA_W-1:0] pw_data;
   logic              pg_rise, err_now;

   pis_rom u_rom (.idx(idx), .addr(rom_addr), .data(rom_data));

   assign pg_rise = pwr_good & ~pg_q;
   assign err_now = wr_req & is_protected(wr_addr);
   assign busy    = (st != ST_OFF) && (st != ST_READY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_OFF;
         cmd       <= CMD_EN;
         tmr       <= '0;
         bl_cnt    <= '0;
         bl_arm    <= 1'b0;
         idx       <= '0;
         pg_q      <= 1'b0;
         pend_en   <= 1'b0;
         pend_dis  <= 1'b0;
         pend_shut <= 1'b0;
         pend_wr   <= 1'b0;
         pw_addr   <= '0;
         pw_data   <= '0;
         spi_start <= 1'b0;
         spi_frame <= '0;
         panel_rst <= 1'b1;
         bl_en     <= 1'b0;
         wr_err    <= 1'b0;
      end else begin
         pg_q      <= pwr_good;
         spi_start <= 1'b0;
         wr_err    <= err_now;

         // backlight delay runs beside the sequencer so requests stay serviceable
         if (bl_arm) begin
            if (bl_cnt == BL_M1) begin
               bl_en  <= 1'b1;
               bl_arm <= 1'b0;
            end else bl_cnt <= bl_cnt + 1'b1;
         end

         case (st)
            ST_OFF: if (pg_rise) begin
               panel_rst <= 1'b1;
               idx       <= '0;
               tmr       <= RST_M1;
               st        <= ST_RST;
            end
            ST_RST: if (tmr == '0) begin
               panel_rst <= 1'b0;
               tmr       <= GAP_M1;
               st        <= ST_POST;
            end else tmr <= tmr - 1'b1;
            ST_POST: if (tmr == '0) st <= ST_INIT_TX;
                     else tmr <= tmr - 1'b1;
            ST_INIT_TX: if (spi_ready) begin
               spi_start <= 1'b1;
               spi_frame <= mk_frame(rom_addr, rom_data);
               st        <= ST_INIT_WAIT;
            end
            ST_INIT_WAIT: if (spi_done) begin
               tmr <= GAP_M1;
               st  <= ST_INIT_GAP;
            end
            ST_INIT_GAP: if (tmr == '0) begin
               if (idx == LAST_IDX) st <= ST_READY;
               else begin
                  idx <= idx + 1'b1;
                  st  <= ST_INIT_TX;
               end
            end else tmr <= tmr - 1'b1;
            ST_READY: if (spi_ready) begin
               if (pend_shut) begin
                  pend_shut <= 1'b0;
                  pend_en   <= 1'b0;
                  pend_dis  <= 1'b0;
                  pend_wr   <= 1'b0;
                  bl_en     <= 1'b0;
                  bl_arm    <= 1'b0;
                  cmd       <= CMD_SHUT;
                  spi_start <= 1'b1;
                  spi_frame <= mk_frame('0, V_STANDBY);
                  st        <= ST_CMD_WAIT;
               end else if (pend_dis) begin
                  pend_dis  <= 1'b0;
                  bl_en     <= 1'b0;
                  bl_arm    <= 1'b0;
                  cmd       <= CMD_DIS;
                  spi_start <= 1'b1;
                  spi_frame <= mk_frame('0, V_STANDBY);
                  st        <= ST_CMD_WAIT;
               end else if (pend_en) begin
                  pend_en   <= 1'b0;
                  cmd       <= CMD_EN;
                  spi_start <= 1'b1;
                  spi_frame <= mk_frame('0, V_ACTIVE);
                  st        <= ST_CMD_WAIT;
               end else if (pend_wr) begin
                  pend_wr   <= 1'b0;
                  cmd       <= CMD_WR;
                  spi_start <= 1'b1;
                  spi_frame <= mk_frame(pw_addr, pw_data);
                  st        <= ST_CMD_WAIT;
               end
            end
            ST_CMD_WAIT: if (spi_done) begin
               if (cmd == CMD_SHUT) begin
                  panel_rst <= 1'b1;
                  st        <= ST_OFF;
               end else begin
                  if (cmd == CMD_EN) begin
                     bl_arm <= 1'b1;
                     bl_cnt <= '0;
                  end
                  tmr <= GAP_M1;
                  st  <= ST_CMD_GAP;
               end
            end
            ST_CMD_GAP: if (tmr == '0) st <= ST_READY;
                        else tmr <= tmr - 1'b1;
            default: st <= ST_OFF;
         endcase

         // capture after dispatch so a request in the dispatch cycle survives
         if (st != ST_OFF) begin
            if (en_req) begin
               pend_en  <= 1'b1;
               pend_dis <= 1'b0;
            end
            if (dis_req) begin
               pend_dis <= 1'b1;
               pend_en  <= 1'b0;
            end
            if (shut_req) pend_shut <= 1'b1;
            if (wr_req && !err_now) begin
               pend_wr <= 1'b1;
               pw_addr <= wr_addr;
               pw_data <= wr_data;
            end
         end
      end
   end

   p_rst_no_bl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      panel_rst |-> !bl_en);
   p_legal_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      spi_start |-> !is_protected(spi_frame[FRAME_W-1 -: ADDR_W]));
   p_start_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      spi_start |-> spi_ready);
   p_err_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $past(wr_req));
endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
   import pis_pkg::*;
#(
   parameter int SCLK_HALF = 4,
   parameter int RST_CYC   = 20000,
   parameter int GAP_CYC   = 400,
   parameter int BL_CYC    = 30000000,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_good,
   input  logic       en_req,
   input  logic       dis_req,
   input  logic       shut_req,
   input  logic       wr_req,
   input  logic [5:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic       panel_rst,
   output logic       spi_sclk,
   output logic       spi_cs_n,
   output logic       spi_sdo,
   output logic       bl_en,
   output logic       busy,
   output logic       wr_err
);
   logic               spi_start, spi_ready, spi_done;
   logic [FRAME_W-1:0] spi_frame;

   pis_ctrl #(.RST_CYC(RST_CYC), .GAP_CYC(GAP_CYC), .BL_CYC(BL_CYC)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
      .en_req(en_req), .dis_req(dis_req), .shut_req(shut_req),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
      .spi_ready(spi_ready), .spi_done(spi_done),
      .spi_start(spi_start), .spi_frame(spi_frame),
      .panel_rst(panel_rst), .bl_en(bl_en), .busy(busy), .wr_err(wr_err)
   );

   pis_spi_tx #(.SCLK_HALF(SCLK_HALF), .MSB_FIRST(MSB_FIRST)) u_spi (
      .clk(clk), .rst_n(rst_n), .start(spi_start), .frame(spi_frame),
      .ready(spi_ready), .done(spi_done),
      .sclk(spi_sclk), .cs_n(spi_cs_n), .sdo(spi_sdo)
   );

   p_busy_frames_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_cs_n) |-> busy);
endmodule

// File: tb/panel_init_seq_tb.sv
module panel_init_seq_tb;
   localparam int HALF = 2;
   localparam int RSTC = 50;
   localparam int GAPC = 8;
   localparam int BLC  = 200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_good = 1'b0, en_req = 1'b0, dis_req = 1'b0, shut_req = 1'b0, wr_req = 1'b0;
   logic [5:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic panel_rst, spi_sclk, spi_cs_n, spi_sdo, bl_en, busy, wr_err;

   always #2.5 clk = ~clk;

   panel_init_seq #(.SCLK_HALF(HALF), .RST_CYC(RSTC), .GAP_CYC(GAPC), .BL_CYC(BLC)) u_dut (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .en_req(en_req), .dis_req(dis_req),
      .shut_req(shut_req), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
      .panel_rst(panel_rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_sdo(spi_sdo),
      .bl_en(bl_en), .busy(busy), .wr_err(wr_err)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic [15:0] exp_q[$];
   string       tag_q[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
      end
   endtask

   task automatic push(input logic [15:0] f, input string tag);
      exp_q.push_back(f);
      tag_q.push_back(tag);
   endtask

   // ---------------- monitor / scoreboard ----------------
   logic        prev_cs = 1'b1, prev_sclk = 1'b1, have_rise = 1'b0;
   logic [15:0] sh = '0;
   int nb = 0, last_rise = 0, sclk_bad = 0, gap_bad = 0, bits_bad = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (spi_cs_n && !spi_sclk) sclk_bad++;
         if (!spi_cs_n && prev_cs) begin
            if (have_rise && (cyc - last_rise) < GAPC) gap_bad++;
            sh = '0;
            nb = 0;
         end
         if (!spi_cs_n && spi_sclk && !prev_sclk) begin
            sh = {sh[14:0], spi_sdo};
            nb++;
         end
         if (spi_cs_n && !prev_cs) begin
            last_rise = cyc;
            have_rise = 1'b1;
            if (nb != 16) bits_bad++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R11 unexpected frame", int'(sh), 0);
            end else begin
               logic [15:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(sh == e, t, int'(sh), int'(e));
            end
         end
      end
      prev_cs   = spi_cs_n;
      prev_sclk = spi_sclk;
   end

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R7 watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // ---------------- stimulus ----------------
   task automatic pulse_en();  @(negedge clk) en_req = 1'b1;  @(negedge clk) en_req = 1'b0;  endtask
   task automatic pulse_dis(); @(negedge clk) dis_req = 1'b1; @(negedge clk) dis_req = 1'b0; endtask
   task automatic pulse_shut(); @(negedge clk) shut_req = 1'b1; @(negedge clk) shut_req = 1'b0; endtask

   task automatic host_wr(input logic [5:0] a, input logic [7:0] d, input bit expect_err);
      @(negedge clk);
      wr_req = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_req = 1'b0;
      chk(wr_err == expect_err, "R11 wr_err after request", int'(wr_err), int'(expect_err));
   endtask

   task automatic wait_quiet();
      @(negedge clk);
      while (exp_q.size() != 0 || !spi_cs_n || busy) @(negedge clk);
   endtask

   task automatic push_init(input string tag);
      logic [7:0] vals[19] = '{8'h00, 8'h00, 8'h03, 8'hCC, 8'h46, 8'h05, 8'h00, 8'h00,
                              8'h08, 8'h40, 8'h88, 8'h88, 8'h20, 8'h20, 8'h67, 8'hA4,
                              8'h04, 8'h24, 8'h24};
      for (int i = 0; i < 19; i++) push({i[5:0], 2'b10, vals[i]}, tag);
      push({6'h20, 2'b10, 8'h00}, tag);
   endtask

   initial begin
      int t0, hold, dly;
      repeat (4) @(negedge clk);
      chk(panel_rst == 1'b1, "R1 panel_rst in reset", int'(panel_rst), 1);
      chk(spi_sclk == 1'b1 && spi_cs_n == 1'b1, "R1 sclk/cs idle in reset",
          int'({spi_sclk, spi_cs_n}), 3);
      chk(bl_en == 1'b0 && busy == 1'b0, "R1 bl_en/busy in reset", int'({bl_en, busy}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(panel_rst == 1'b1 && spi_sclk == 1'b1 && spi_cs_n == 1'b1 && !busy,
          "R1 state after reset release", int'({panel_rst, spi_sclk, spi_cs_n, busy}), 4'hE);

      // bring-up with an enable held pending while busy
      push_init("R5 init table frame");
      push(16'h0203, "R7 pending enable frame");
      @(negedge clk) pwr_good = 1'b1;
      t0 = cyc;
      repeat (3) @(negedge clk);
      chk(busy == 1'b1, "R7 busy after power good", int'(busy), 1);
      pulse_en();
      while (panel_rst) @(negedge clk);
      hold = cyc - t0;
      chk(hold >= RSTC && hold <= RSTC + 3, "R4 reset hold cycles", hold, RSTC);
      t0 = cyc;
      while (spi_cs_n) @(negedge clk);
      chk((cyc - t0) >= GAPC, "R4 settle before first frame", cyc - t0, GAPC);
      wait_quiet();
      while (!bl_en) @(negedge clk);
      dly = cyc - last_rise;
      chk(dly >= BLC && dly <= BLC + 2*HALF + 4, "R8 backlight delay", dly, BLC + 2*HALF + 1);

      // host writes
      push(16'h2A5A, "R11 legal write 0x0A");
      host_wr(6'h0A, 8'h5A, 1'b0);
      wait_quiet();
      push(16'h8233, "R11 legal write 0x20");
      host_wr(6'h20, 8'h33, 1'b0);
      wait_quiet();
      host_wr(6'h15, 8'h11, 1'b1);
      host_wr(6'h1F, 8'h22, 1'b1);
      host_wr(6'h21, 8'h44, 1'b1);
      host_wr(6'h13, 8'h55, 1'b1);
      repeat (150) @(negedge clk);
      chk(spi_cs_n == 1'b1 && exp_q.size() == 0, "R11 protected writes send nothing",
          int'(spi_cs_n), 1);

      // disable: backlight off before its frame
      push(16'h0201, "R9 disable frame");
      pulse_dis();
      while (spi_cs_n) @(negedge clk);
      chk(bl_en == 1'b0, "R9 backlight off at frame start", int'(bl_en), 0);
      wait_quiet();

      // enable then shutdown
      push(16'h0203, "R8 enable frame");
      pulse_en();
      wait_quiet();
      while (!bl_en) @(negedge clk);
      push(16'h0201, "R10 shutdown standby frame");
      pulse_shut();
      while (spi_cs_n) @(negedge clk);
      chk(bl_en == 1'b0 && panel_rst == 1'b0, "R10 bl off, reset low during frame",
          int'({bl_en, panel_rst}), 0);
      while (!spi_cs_n) @(negedge clk);
      repeat (2*HALF + 4) @(negedge clk);
      chk(panel_rst == 1'b1, "R10 reset reasserted after frame", int'(panel_rst), 1);
      chk(busy == 1'b0, "R10 idle after shutdown", int'(busy), 0);

      // second bring-up: enable then disable while busy, disable must win
      @(negedge clk) pwr_good = 1'b0;
      repeat (5) @(negedge clk);
      push_init("R5 second init frame");
      push(16'h0201, "R7 last pending request wins");
      @(negedge clk) pwr_good = 1'b1;
      repeat (5) @(negedge clk);
      pulse_en();
      pulse_dis();
      wait_quiet();
      repeat (BLC + 50) @(negedge clk);
      chk(bl_en == 1'b0, "R7 overridden enable has no effect", int'(bl_en), 0);

      chk(exp_q.size() == 0, "R5 all expected frames seen", exp_q.size(), 0);
      chk(sclk_bad == 0, "R3 sclk idle high while deselected", sclk_bad, 0);
      chk(gap_bad == 0, "R6 deselect gap between frames", gap_bad, 0);
      chk(bits_bad == 0, "R2 sixteen clocks per frame", bits_bad, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule